// File: doc/BRIEF.md
# Memory Controller Frequency Epoch Sequencer

This block drives the periodic frequency and voltage management of a single memory controller together with its channel and DRAM devices. Time is cut into fixed-length epochs counted in reference clock ticks. Each epoch runs four phases in a fixed order. The first is a profiling window. The second is a short window in which software may post a new frequency level. The third is a transition, in which memory traffic is stalled. The last runs at the chosen setting until the epoch ends. Each controller in a chip gets its own instance, so different controllers can sit at different levels at the same time.

Software works through a small register port. It writes a level code between 0 (fastest) and 9 (slowest), and it reads back a status word. When a new level is applied, the block publishes three clock frequency words in a fixed 4:2:1 ratio for the controller, channel and device clocks. It also publishes a voltage code for the controller alone. It then holds a stall output for the recalibration time the new frequency needs. The choice of level is made by software and is outside this block.

Top module: `mem_dvfs_seq`

## Requirements
- R1: Counting from the epoch start, the phase is profile (code 0) for PROF_TICKS cycles. It is then select (code 1) for SEL_TICKS cycles. After that comes transition (code 2) if a change is due, then run (code 3). Every EPOCH_TICKS cycles the sequence restarts at profile.
- R2: A write to address 0 during the select phase posts the level in data bits [3:0]. When the select phase ends, the most recent posted level is used, and a write in the final select cycle still counts.
- R3: A write to address 0 is ignored if the full 8-bit data value is above 9, or if it arrives outside the select phase.
- R4: If no level is posted by the end of select, or the posted level equals the current one, the block goes straight to run with no stall and the level unchanged.
- R5: When a different level is posted, the new level becomes current in the first transition cycle. mem_stall is high for exactly ceil(512*REF_MHZ/f) + ceil(28*REF_MHZ/1000) cycles, where f is the new channel frequency in MHz.
- R6: ch_mhz follows the level as 800, 733, 667, 600, 533, 467, 400, 333, 267, 200 for levels 0 to 9. mc_mhz is twice ch_mhz, and dev_mhz is ch_mhz shifted right by one.
- R7: mc_vcode, in 10 mV steps, equals 65 + ((9-level)*55+4)/9 using integer division. This gives 120 at level 0 and 65 at level 9.
- R8: Reading address 1 returns {done, 0, phase[1:0], level[3:0]}, and reading address 0 returns {4'b0, level}. The done bit is set in the cycle a transition ends. A write to address 1 with bit 7 set clears it, but setting wins when both happen in the same cycle.
- R9: During reset the phase is profile, the level is 0, done is 0 and mem_stall is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address (0 level, 1 status) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| mem_stall | output | 1 | Traffic stall during a transition |
| mc_mhz | output | 12 | Controller clock frequency word |
| ch_mhz | output | 12 | Channel clock frequency word |
| dev_mhz | output | 12 | Device clock frequency word |
| mc_vcode | output | 7 | Controller voltage code |

## Verification
Every register in the block updates on the edge after its input. A level posted in the final select cycle therefore appears in reg_rdata, the frequency words and the voltage code one edge later, together with the first high cycle of mem_stall. Phase changes show in the status word on the edge where the epoch count crosses each boundary. The bench runs its own reference model, stepped on the same rising edge as the design. It compares every output on the falling edge that follows, so each result is checked in the exact cycle it is due. Stall lengths are also totalled per epoch and compared with the expected figure.

// File: rtl/memdvfs_pkg.sv
package memdvfs_pkg;
    localparam int NUM_LEVELS = 10;
    localparam int LVL_W      = 4;
    localparam int FREQ_W     = 12;
    localparam int VC_W       = 7;

    typedef enum logic [1:0] {
        PH_PROF = 2'd0,
        PH_SEL  = 2'd1,
        PH_XFER = 2'd2,
        PH_RUN  = 2'd3
    } phase_e;

    // Channel frequency in MHz for a level code 0..9.
    function automatic logic [FREQ_W-1:0] ch_mhz_of(input logic [LVL_W-1:0] lvl);
        int li;
        li = int'(lvl);
        return FREQ_W'(800 - (li * 200 + 1) / 3);
    endfunction

    // Stall length in reference ticks: 512 channel cycles plus 28 ns, each rounded up.
    function automatic int stall_ticks_of(input logic [LVL_W-1:0] lvl, input int ref_mhz);
        int f;
        f = int'(ch_mhz_of(lvl));
        return (512 * ref_mhz + f - 1) / f + (28 * ref_mhz + 999) / 1000;
    endfunction

    // Controller voltage code in 10 mV units, 0.65 V .. 1.20 V.
    function automatic logic [VC_W-1:0] vcode_of(input logic [LVL_W-1:0] lvl);
        int li;
        li = int'(lvl);
        return VC_W'(65 + ((NUM_LEVELS - 1 - li) * 55 + 4) / 9);
    endfunction
endpackage

// File: rtl/dvfs_level_table.sv
module dvfs_level_table
    import memdvfs_pkg::*;
(
    input  logic [LVL_W-1:0]  level,
    output logic [FREQ_W-1:0] mc_mhz,
    output logic [FREQ_W-1:0] ch_mhz,
    output logic [FREQ_W-1:0] dev_mhz,
    output logic [VC_W-1:0]   vcode
);
    localparam int ROWS = 1 << LVL_W;

    logic [FREQ_W-1:0] ch_rom [ROWS];
    logic [VC_W-1:0]   vc_rom [ROWS];

    // Rows past the last level repeat the slowest setting.
    for (genvar g = 0; g < ROWS; g++) begin : g_row
        localparam logic [LVL_W-1:0] IDX = (g < NUM_LEVELS) ? LVL_W'(g) : LVL_W'(NUM_LEVELS - 1);
        assign ch_rom[g] = ch_mhz_of(IDX);
        assign vc_rom[g] = vcode_of(IDX);
    end

    always_comb begin
        ch_mhz  = ch_rom[level];
        mc_mhz  = {ch_rom[level][FREQ_W-2:0], 1'b0};
        dev_mhz = {1'b0, ch_rom[level][FREQ_W-1:1]};
        vcode   = vc_rom[level];
    end
endmodule

// File: rtl/dvfs_epoch_fsm.sv
module dvfs_epoch_fsm
    import memdvfs_pkg::*;
#(
    parameter int REF_MHZ     = 100,
    parameter int EPOCH_TICKS = 500000,
    parameter int PROF_TICKS  = 30000,
    parameter int SEL_TICKS   = 1000,
    parameter int STALL_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_wr,
    input  logic [LVL_W-1:0] lvl_wdata,
    input  logic             done_clr,
    output phase_e           phase,
    output logic [LVL_W-1:0] level,
    output logic             done,
    output logic             stall
);
    localparam int CNT_W = $clog2(EPOCH_TICKS);
    localparam logic [CNT_W-1:0] EPOCH_END = CNT_W'(EPOCH_TICKS - 1);
    localparam logic [CNT_W-1:0] PROF_END  = CNT_W'(PROF_TICKS - 1);
    localparam logic [CNT_W-1:0] SEL_END   = CNT_W'(PROF_TICKS + SEL_TICKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        phase_e             phase;
        logic [STALL_W-1:0] tcnt;
        logic [LVL_W-1:0]   level;
        logic               pend_vld;
        logic [LVL_W-1:0]   pend_lvl;
        logic               done;
    } state_t;

    state_t st_q, st_d;

    always_comb begin
        logic set_done;
        st_d     = st_q;
        set_done = 1'b0;
        st_d.cnt = (st_q.cnt == EPOCH_END) ? '0 : st_q.cnt + 1'b1;

        if (lvl_wr && st_q.phase == PH_SEL) begin
            st_d.pend_vld = 1'b1;
            st_d.pend_lvl = lvl_wdata;
        end

        case (st_q.phase)
            PH_PROF: if (st_q.cnt == PROF_END) st_d.phase = PH_SEL;
            PH_SEL: if (st_q.cnt == SEL_END) begin
                if (st_d.pend_vld && st_d.pend_lvl != st_q.level) begin
                    st_d.phase = PH_XFER;
                    st_d.level = st_d.pend_lvl;
                    st_d.tcnt  = STALL_W'(stall_ticks_of(st_d.pend_lvl, REF_MHZ) - 1);
                end else begin
                    st_d.phase = PH_RUN;
                end
                st_d.pend_vld = 1'b0;
            end
            PH_XFER: if (st_q.tcnt == '0) begin
                st_d.phase = PH_RUN;
                set_done   = 1'b1;
            end else begin
                st_d.tcnt = st_q.tcnt - 1'b1;
            end
            default: ;
        endcase

        if (st_q.cnt == EPOCH_END) st_d.phase = PH_PROF;

        if (set_done)      st_d.done = 1'b1;
        else if (done_clr) st_d.done = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.phase    <= PH_PROF;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;
    assign level = st_q.level;
    assign done  = st_q.done;
    assign stall = (st_q.phase == PH_XFER);
endmodule

// File: rtl/mem_dvfs_seq.sv
module mem_dvfs_seq
    import memdvfs_pkg::*;
#(
    parameter int REF_MHZ     = 100,
    parameter int EPOCH_TICKS = 500000,
    parameter int PROF_TICKS  = 30000,
    parameter int SEL_TICKS   = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              mem_stall,
    output logic [FREQ_W-1:0] mc_mhz,
    output logic [FREQ_W-1:0] ch_mhz,
    output logic [FREQ_W-1:0] dev_mhz,
    output logic [VC_W-1:0]   mc_vcode
);
    phase_e           phase;
    logic [LVL_W-1:0] level;
    logic             done;
    logic             lvl_wr;
    logic             done_clr;

    always_comb begin
        lvl_wr   = reg_wr && !reg_addr && (reg_wdata <= 8'(NUM_LEVELS - 1));
        done_clr = reg_wr && reg_addr && reg_wdata[7];
        reg_rdata = reg_addr ? {done, 1'b0, phase, level} : {4'b0, level};
    end

    dvfs_epoch_fsm #(
        .REF_MHZ    (REF_MHZ),
        .EPOCH_TICKS(EPOCH_TICKS),
        .PROF_TICKS (PROF_TICKS),
        .SEL_TICKS  (SEL_TICKS),
        .STALL_W    (16)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_wr   (lvl_wr),
        .lvl_wdata(reg_wdata[LVL_W-1:0]),
        .done_clr (done_clr),
        .phase    (phase),
        .level    (level),
        .done     (done),
        .stall    (mem_stall)
    );

    dvfs_level_table u_tab (
        .level  (level),
        .mc_mhz (mc_mhz),
        .ch_mhz (ch_mhz),
        .dev_mhz(dev_mhz),
        .vcode  (mc_vcode)
    );
endmodule

// File: rtl/mem_dvfs_seq_chk.sv
module mem_dvfs_seq_chk
    import memdvfs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input phase_e            phase,
    input logic [LVL_W-1:0]  level,
    input logic              done,
    input logic              mem_stall,
    input logic [FREQ_W-1:0] mc_mhz,
    input logic [FREQ_W-1:0] ch_mhz,
    input logic [FREQ_W-1:0] dev_mhz,
    input logic [VC_W-1:0]   mc_vcode
);
    assert_prof_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_PROF |=> (phase == PH_PROF || phase == PH_SEL));

    assert_level_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(NUM_LEVELS - 1));

    assert_stall_after_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_stall) |-> $past(phase) == PH_SEL);

    assert_level_moves_with_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level) |-> mem_stall);

    assert_clock_ratio_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mc_mhz == {ch_mhz[FREQ_W-2:0], 1'b0} && dev_mhz == (ch_mhz >> 1));

    assert_vcode_span_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mc_vcode >= 7'd65 && mc_vcode <= 7'd120);

    assert_done_on_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_stall) |-> done);
endmodule

bind mem_dvfs_seq mem_dvfs_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .level    (level),
    .done     (done),
    .mem_stall(mem_stall),
    .mc_mhz   (mc_mhz),
    .ch_mhz   (ch_mhz),
    .dev_mhz  (dev_mhz),
    .mc_vcode (mc_vcode)
);

// File: tb/mem_dvfs_seq_test.sv
module mem_dvfs_seq_test;
    localparam int EP = 400, PR = 20, SL = 10, REFM = 100, EPOCHS = 40;

    logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        mem_stall;
    logic [11:0] mc_mhz, ch_mhz, dev_mhz;
    logic [6:0]  mc_vcode;

    mem_dvfs_seq #(.REF_MHZ(REFM), .EPOCH_TICKS(EP), .PROF_TICKS(PR), .SEL_TICKS(SL)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mem_stall(mem_stall), .mc_mhz(mc_mhz), .ch_mhz(ch_mhz),
        .dev_mhz(dev_mhz), .mc_vcode(mc_vcode));

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int m_cnt = 0, m_phase = 0, m_tleft = 0, m_level = 0, m_pv = 0, m_pl = 0, m_done = 0, m_epoch = 0;
    int stall_seen [EPOCHS];

    function automatic int freq_tab(input int l);
        case (l)
            0: return 800; 1: return 733; 2: return 667; 3: return 600; 4: return 533;
            5: return 467; 6: return 400; 7: return 333; 8: return 267; default: return 200;
        endcase
    endfunction

    function automatic int stall_exp(input int l);
        int f;
        f = freq_tab(l);
        return (512 * REFM + f - 1) / f + (28 * REFM + 999) / 1000;
    endfunction

    function automatic int vc_exp(input int l);
        return 65 + ((9 - l) * 55 + 4) / 9;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (epoch %0d tick %0d)", tag, act, exp, m_epoch, m_cnt);
        end
    endtask

    // Reference model, stepped on the same edge as the design.
    always @(posedge clk) begin
        int set_d;
        if (rst_n) begin
            set_d = 0;
            if (m_phase == 1 && reg_wr && !reg_addr && reg_wdata <= 8'd9) begin
                m_pv = 1;
                m_pl = int'(reg_wdata);
            end
            case (m_phase)
                0: if (m_cnt == PR - 1) m_phase = 1;
                1: if (m_cnt == PR + SL - 1) begin
                    if (m_pv != 0 && m_pl != m_level) begin
                        m_phase = 2; m_level = m_pl; m_tleft = stall_exp(m_pl);
                    end else m_phase = 3;
                    m_pv = 0;
                end
                2: begin
                    m_tleft--;
                    if (m_tleft == 0) begin m_phase = 3; set_d = 1; end
                end
                default: ;
            endcase
            if (m_cnt == EP - 1) begin m_cnt = 0; m_phase = 0; m_epoch++; end
            else m_cnt++;
            if (set_d != 0) m_done = 1;
            else if (reg_wr && reg_addr && reg_wdata[7]) m_done = 0;
        end
    end

    task automatic wr(input logic a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    endtask

    initial begin
        void'($urandom(32'd20250611));
        for (int i = 0; i < EPOCHS; i++) stall_seen[i] = 0;
        reg_addr = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk("R9 status", int'(reg_rdata), 0);
        chk("R9 stall", int'(mem_stall), 0);
        chk("R9 ch_mhz", int'(ch_mhz), 800);
        chk("R9 vcode", int'(mc_vcode), 120);
        rst_n = 1'b1;
        while (m_epoch < EPOCHS) begin
            int s;
            @(negedge clk);
            if (m_epoch >= EPOCHS) break;
            if (mem_stall) stall_seen[m_epoch]++;
            chk("R5 stall", int'(mem_stall), (m_phase == 2) ? 1 : 0);
            if (reg_addr)
                chk("R1 R8 status", int'(reg_rdata), m_done * 128 + m_phase * 16 + m_level);
            else
                chk("R2 R3 R4 level", int'(reg_rdata), m_level);
            chk("R6 ch_mhz", int'(ch_mhz), freq_tab(m_level));
            chk("R6 mc_mhz", int'(mc_mhz), 2 * freq_tab(m_level));
            chk("R6 dev_mhz", int'(dev_mhz), freq_tab(m_level) / 2);
            chk("R7 vcode", int'(mc_vcode), vc_exp(m_level));

            reg_wr = 1'b0; reg_addr = 1'($urandom % 2); reg_wdata = 8'($urandom);
            s = m_cnt - PR;
            if (m_phase == 1) begin
                if ((m_epoch == 1 || m_epoch == 2) && s == 2) wr(1'b0, 8'd9);
                else if (m_epoch == 3 && s == 2) wr(1'b0, 8'd12);
                else if (m_epoch == 4 && s == 1) wr(1'b0, 8'd3);
                else if (m_epoch == 4 && s == SL - 1) wr(1'b0, 8'd0);
                else if (m_epoch >= 5 && $urandom % 4 == 0) wr(1'b0, 8'($urandom % 13));
            end else if (m_epoch == 2 && m_phase == 3 && m_cnt == PR + SL) begin
                wr(1'b0, 8'd4);
            end else if (m_epoch >= 5 && $urandom % 8 == 0) begin
                wr(1'b0, 8'($urandom % 10));
            end
            if (!reg_wr && $urandom % 16 == 0) wr(1'b1, 8'h80);
        end
        // Directed per-epoch stall totals
        chk("R4 no post keeps level", stall_seen[0], 0);
        chk("R5 stall length level 9", stall_seen[1], stall_exp(9));
        chk("R4 same level no stall", stall_seen[2], 0);
        chk("R3 invalid level ignored", stall_seen[3], 0);
        chk("R2 last select write wins", stall_seen[4], stall_exp(0));
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", m_epoch, EPOCHS);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule